// File: doc/BRIEF.md
# DMA Address Window Guard

This block holds a protected address window and judges 32-bit DMA addresses against it. Software programs the window through a single register write port. A write to the window register is accepted only when its upper half carries a fixed 16-bit unlock key. The window has two 7-bit fields. Each field picks a 1 MiB granule inside one fixed memory area: one field gives the lowest legal address and the other gives the highest.

The same write port also loads a transfer start-address register. As the value is stored, it is checked against the window currently in force, and a failing start address raises an illegal-address interrupt pulse. A combinational query port returns pass or fail for any address in the same cycle. A separate probe port carries addresses seen during a transfer, and it raises an overrun interrupt pulse whenever a probed address falls outside the window.

Top module: `dma_window_guard`

## Requirements
- R1: After reset, `winValue` reads 0x00007F00, `startAddr` reads 0, and both interrupt outputs are low.
- R2: A write with `wrSel`=0 whose `wrData[31:16]` equals 0x6155 stores `wrData & 0x00007F7F` into the window register, visible on `winValue` after the next rising edge.
- R3: A window write with any other key leaves `winValue` unchanged and raises no interrupt.
- R4: The lowest legal address is `0x08000000 | (winValue[14:8] << 20)` and the highest is `0x080FFFE0 | (winValue[6:0] << 20)`. An address equal to either limit passes, and one step beyond either limit fails.
- R5: An address passes only if its bits 28:26 equal 3. An address inside the numeric limits but in another area fails.
- R6: `chkPass` is a combinational function of `chkAddr` and the stored window, valid in the same cycle.
- R7: A write with `wrSel`=1 stores `wrData & 0x1FFFFFE0` into `startAddr`, visible after the next rising edge. No key is required.
- R8: `irqIllegal` is high for exactly the one cycle after a start-address write, and only when the stored address fails against the window in force at that write.
- R9: `irqOverrun` is high in the cycle after a cycle in which `ovrValid` is high and `ovrAddr` fails the check. It stays low when `ovrValid` is low or when the address passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the window register, 1 selects the start-address register |
| wrData | input | 32 | Write data, including the key in bits 31:16 for window writes |
| chkAddr | input | 32 | Address to query |
| chkPass | output | 1 | High when `chkAddr` lies inside the window |
| ovrValid | input | 1 | Qualifies `ovrAddr` for the overrun probe |
| ovrAddr | input | 32 | Address reached during a transfer |
| winValue | output | 32 | Stored window register |
| startAddr | output | 32 | Stored start address |
| irqIllegal | output | 1 | One-cycle pulse for an illegal start address |
| irqOverrun | output | 1 | One-cycle pulse for a failed overrun probe |

## Verification
The bench tries the range check with random windows and addresses drawn from three pools: addresses in the legal area, addresses in the neighbouring area, and fully random words. These pools separate the area test from the numeric bound test. Directed addresses sit exactly on each limit and one step beyond it, which exposes an off-by-one in either comparator or a swapped bound field. Window writes with the key and without it show whether the key is enforced. Start writes whose data bits outside the mask are set show whether the mask is applied before the check. Overrun probes are sent with the qualifier both high and low.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int ADDR_W      = 32;
  localparam int FIELD_W     = 7;
  localparam int GRAN_SHIFT  = 20;
  localparam int KEY_W       = 16;
  localparam int KEY_LSB     = ADDR_W - KEY_W;
  localparam int LO_FIELD_LSB = 8;
  localparam int HI_FIELD_LSB = 0;
  localparam int AREA_LSB    = 26;
  localparam int AREA_W      = 3;
  localparam int NUM_PROBES  = 3;

  localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'h6155;
  localparam logic [AREA_W-1:0] AREA_ID    = 3'd3;
  localparam logic [ADDR_W-1:0] WIN_MASK   = 32'h0000_7F7F;
  localparam logic [ADDR_W-1:0] START_MASK = 32'h1FFF_FFE0;
  localparam logic [ADDR_W-1:0] WIN_RESET  = 32'h0000_7F00;
  localparam logic [ADDR_W-1:0] LO_BASE    = 32'h0800_0000;
  localparam logic [ADDR_W-1:0] HI_BASE    = 32'h080F_FFE0;

  typedef enum logic {SEL_WINDOW = 1'b0, SEL_START = 1'b1} wsel_e;

  typedef struct packed {
    logic loadWin;
    logic loadStart;
    logic ovrProbe;
  } strobe_t;

  typedef enum int {PROBE_QUERY = 0, PROBE_START = 1, PROBE_OVR = 2} probe_e;
endpackage

// File: rtl/dwg_range_cmp.sv
module dwg_range_cmp
  import dwg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] loBound,
  input  logic [AW-1:0] hiBound,
  output logic          inWindow
);
  logic areaHit;
  logic aboveLo;
  logic belowHi;

  always_comb begin
    areaHit  = (addr[AREA_LSB +: AREA_W] == AREA_ID);
    aboveLo  = (addr >= loBound);
    belowHi  = (addr <= hiBound);
    inWindow = areaHit && aboveLo && belowHi;
  end
endmodule

// File: rtl/dwg_ctrl.sv
module dwg_ctrl
  import dwg_pkg::*;
(
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [KEY_W-1:0] wrKey,
  input  logic             ovrValid,
  output strobe_t          strobes
);
  logic keyMatch;
  logic selWin;
  logic selStart;

  always_comb begin
    keyMatch = (wrKey == UNLOCK_KEY);
    selWin   = (wsel_e'(wrSel) == SEL_WINDOW);
    selStart = (wsel_e'(wrSel) == SEL_START);
    strobes.loadWin   = wrEn && selWin && keyMatch;
    strobes.loadStart = wrEn && selStart;
    strobes.ovrProbe  = ovrValid;
  end
endmodule

// File: rtl/dwg_datapath.sv
module dwg_datapath
  import dwg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic [ADDR_W-1:0] ovrAddr,
  output logic [ADDR_W-1:0] winValue,
  output logic [ADDR_W-1:0] startAddr,
  output logic              chkPass,
  output logic              irqIllegal,
  output logic              irqOverrun
);
  logic [ADDR_W-1:0]  winReg;
  logic [ADDR_W-1:0]  startReg;
  logic [ADDR_W-1:0]  loBound;
  logic [ADDR_W-1:0]  hiBound;
  logic [ADDR_W-1:0]  startCand;
  logic [FIELD_W-1:0] loField;
  logic [FIELD_W-1:0] hiField;
  logic [ADDR_W-1:0]  probeAddr [NUM_PROBES];
  logic [NUM_PROBES-1:0] probePass;

  always_comb begin
    loField   = winReg[LO_FIELD_LSB +: FIELD_W];
    hiField   = winReg[HI_FIELD_LSB +: FIELD_W];
    loBound   = LO_BASE | (ADDR_W'(loField) << GRAN_SHIFT);
    hiBound   = HI_BASE | (ADDR_W'(hiField) << GRAN_SHIFT);
    startCand = wrData & START_MASK;
    probeAddr[PROBE_QUERY] = chkAddr;
    probeAddr[PROBE_START] = startCand;
    probeAddr[PROBE_OVR]   = ovrAddr;
  end

  for (genvar gi = 0; gi < NUM_PROBES; gi++) begin : g_probe
    dwg_range_cmp #(.AW(ADDR_W)) u_cmp (
      .addr     (probeAddr[gi]),
      .loBound  (loBound),
      .hiBound  (hiBound),
      .inWindow (probePass[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winReg     <= WIN_RESET;
      startReg   <= '0;
      irqIllegal <= 1'b0;
      irqOverrun <= 1'b0;
    end else begin
      if (strobes.loadWin)   winReg   <= wrData & WIN_MASK;
      if (strobes.loadStart) startReg <= startCand;
      irqIllegal <= strobes.loadStart && !probePass[PROBE_START];
      irqOverrun <= strobes.ovrProbe  && !probePass[PROBE_OVR];
    end
  end

  assign winValue  = winReg;
  assign startAddr = startReg;
  assign chkPass   = probePass[PROBE_QUERY];
endmodule

// File: rtl/dma_window_guard.sv
module dma_window_guard
  import dwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  input  logic [31:0] chkAddr,
  output logic        chkPass,
  input  logic        ovrValid,
  input  logic [31:0] ovrAddr,
  output logic [31:0] winValue,
  output logic [31:0] startAddr,
  output logic        irqIllegal,
  output logic        irqOverrun
);
  strobe_t strobes;

  dwg_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrKey    (wrData[KEY_LSB +: KEY_W]),
    .ovrValid (ovrValid),
    .strobes  (strobes)
  );

  dwg_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .wrData     (wrData),
    .chkAddr    (chkAddr),
    .ovrAddr    (ovrAddr),
    .winValue   (winValue),
    .startAddr  (startAddr),
    .chkPass    (chkPass),
    .irqIllegal (irqIllegal),
    .irqOverrun (irqOverrun)
  );
endmodule

// File: rtl/dwg_checker.sv
module dwg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        wrSel,
  input logic [31:0] wrData,
  input logic [31:0] chkAddr,
  input logic        chkPass,
  input logic        ovrValid,
  input logic [31:0] ovrAddr,
  input logic [31:0] winValue,
  input logic [31:0] startAddr,
  input logic        irqIllegal,
  input logic        irqOverrun
);
  // R3: a window write with the wrong key keeps the register
  p_wrong_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrSel && wrData[31:16] != 16'h6155) |=> $stable(winValue));

  // R2: the window register never holds bits outside its two fields
  p_win_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (winValue & ~32'h0000_7F7F) == 32'h0);

  // R7: the start register never holds masked-off bits
  p_start_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (startAddr & ~32'h1FFF_FFE0) == 32'h0);

  // R8: an illegal-address pulse follows only a start write
  p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqIllegal |-> $past(wrEn && wrSel));

  // R9: no overrun pulse without a qualified probe
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovrValid |=> !irqOverrun);

  // R7: the start register only changes on a start write
  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && wrSel) |=> $stable(startAddr));
endmodule

bind dma_window_guard dwg_checker u_chk (.*);

// File: tb/tb_dma_window_guard.sv
`timescale 1ns/1ps
module tb_dma_window_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrEn, wrSel, ovrValid;
  logic [31:0] wrData, chkAddr, ovrAddr;
  logic        chkPass, irqIllegal, irqOverrun;
  logic [31:0] winValue, startAddr;

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] mWin;
  logic [31:0] mStart;

  always #2.5 clk = ~clk;

  dma_window_guard dut (.*);

  function automatic logic modelPass(input logic [31:0] a, input logic [31:0] w);
    logic [31:0] lo, hi;
    lo = 32'h0800_0000 | ({25'd0, w[14:8]} << 20);
    hi = 32'h080F_FFE0 | ({25'd0, w[6:0]} << 20);
    return (a[28:26] == 3'd3) && (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [31:0] genAddr();
    int pick = $urandom % 3;
    if (pick == 0) return 32'h0C00_0000 | ($urandom & 32'h03FF_FFFF);
    if (pick == 1) return 32'h0800_0000 | ($urandom & 32'h07FF_FFFF);
    return $urandom;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeWin(input logic [31:0] d);
    writeReg(1'b0, d);
    if (d[31:16] == 16'h6155) mWin = d & 32'h0000_7F7F;
    cmp(d[31:16] == 16'h6155 ? "R2 winValue" : "R3 winValue", winValue, mWin);
    cmp("R3 irqIllegal quiet", {31'd0, irqIllegal}, 32'd0);
  endtask

  task automatic writeStart(input logic [31:0] d);
    logic expIrq;
    mStart = d & 32'h1FFF_FFE0;
    expIrq = !modelPass(mStart, mWin);
    writeReg(1'b1, d);
    cmp("R7 startAddr", startAddr, mStart);
    cmp("R8 irqIllegal", {31'd0, irqIllegal}, {31'd0, expIrq});
    @(negedge clk);
    cmp("R8 irqIllegal pulse end", {31'd0, irqIllegal}, 32'd0);
  endtask

  task automatic query(input logic [31:0] a, input string tag);
    chkAddr = a;
    #1;
    cmp(tag, {31'd0, chkPass}, {31'd0, modelPass(a, mWin)});
  endtask

  task automatic probe(input logic v, input logic [31:0] a);
    @(negedge clk);
    ovrValid = v; ovrAddr = a;
    @(negedge clk);
    ovrValid = 1'b0;
    cmp("R9 irqOverrun", {31'd0, irqOverrun}, {31'd0, v && !modelPass(a, mWin)});
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    chkAddr = '0; ovrValid = 1'b0; ovrAddr = '0;
    mWin = 32'h0000_7F00; mStart = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 winValue", winValue, 32'h0000_7F00);
    cmp("R1 startAddr", startAddr, 32'd0);
    cmp("R1 irqs", {30'd0, irqIllegal, irqOverrun}, 32'd0);
    query(32'h0C00_0000, "R6 reset window rejects");

    // R2/R3 key handling with stray bits set
    writeWin(32'h6155_FFFF);
    writeWin(32'h6154_0102);
    writeWin(32'h0000_0000);
    // R4 and R5 boundaries: lo field 0x40, hi field 0x45
    writeWin(32'h6155_4045);
    query(32'h0C00_0000, "R4 lower limit passes");
    query(32'h0BFF_FFFF, "R4 below lower fails");
    query(32'h0C5F_FFE0, "R4 upper limit passes");
    query(32'h0C5F_FFE1, "R4 above upper fails");
    writeWin(32'h6155_007F);
    query(32'h0900_0000, "R5 other area fails");
    query(32'h0D00_0000, "R5 legal area passes");
    query(32'h1D00_0000, "R5 bit28 set fails");
    // R7/R8 masked start writes
    writeStart(32'hED00_001F);
    writeStart(32'h0900_0000);
    // R9 probe qualifier
    probe(1'b1, 32'h0900_0000);
    probe(1'b0, 32'h0900_0000);
    probe(1'b1, 32'h0D00_0000);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = {($urandom % 5 == 0) ? 16'($urandom) : 16'h6155,
           1'b0, 7'(($urandom % 2) ? ($urandom | 32'h40) : $urandom), 1'b0, 7'($urandom | 32'h40)};
      if ($urandom % 4 == 0) d[15] = 1'b1;
      writeWin(d);
      query(genAddr(), "R6 random query");
      writeStart(genAddr());
      probe(1'($urandom), genAddr());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule